// File: doc/BRIEF.md
# Stage-Gated Modular Parity Checker

This block evaluates the parity checks of a code word that has just been read from memory. The full check matrix is a vertical stack of `GAMMA` stages. Every stage first reorders the code word bits with its own fixed permutation. It then applies the same sparse base check unit, which is a bank of `M` exclusive-OR checks with `RHO` inputs each. Each bit of the word enters exactly one check per stage.

A controller supplies a stage mask along with each word. Only the stages that are switched on produce syndromes, so the effective number of checks, and with it the correction strength seen by a downstream majority voter, can be changed from one word to the next. The stage permutations are fixed when the block is built, and stage 0 is the identity. The same datapath with a different base unit can serve as the write-side encoder.

The block has a single register stage. It accepts one word every cycle and presents per-stage syndromes and per-stage valid flags one clock after the word is accepted.

Top module: `stage_gated_checker`

## Requirements
- R1: While reset is asserted, and until the first accepted word has passed through, every syndrome bit and every valid flag reads 0.
- R2: With `N = M*RHO` (16 by default), syndrome bit `j` of stage `s` is the XOR of word bits `((j*RHO + r) * STRIDES[s]) mod N` for `r = 0..RHO-1`. The default strides are 1, 3, 5 and 7. Stage `s` occupies `syn_o[s*M +: M]`.
- R3: A word accepted on a rising edge with `in_valid` high has its syndromes and valid flags on the outputs right after that same edge, which is one cycle of latency.
- R4: Words presented on consecutive cycles are all accepted, and each one produces its own result on the following cycle.
- R5: A stage whose mask bit (`in_mask[s]`) is 0 for an accepted word drives its syndrome slice to all zeros and its valid flag `syn_vld_o[s]` low for that word.
- R6: The mask is sampled together with the word. A later change of `in_mask` does not alter a result that has already been captured.
- R7: In the cycle after an edge at which `in_valid` is low, all valid flags are low and all syndromes are zero, whatever the mask is.
- R8: Stage 0 uses the identity permutation. Its check `j` therefore covers the contiguous bits `j*RHO` to `j*RHO+RHO-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | The word and mask are presented this cycle |
| in_word | input | N | Code word read from memory |
| in_mask | input | GAMMA | Stage enables, bit s for stage s |
| syn_o | output | GAMMA*M | Per-stage syndromes, stage s in bits s*M+M-1 down to s*M |
| syn_vld_o | output | GAMMA | Per-stage result valid flags |

## Verification
The hardest case to reach from the ports is a mask change that overlaps a word still in the register. In that case the old mask must stay attached to the captured result while a new mask already sits on the input. The stimulus accepts a word with every stage enabled and clears the mask on the very next cycle. It then swaps complementary masks on back-to-back words, and the reference model compares every cycle against the mask that was paired with each word. The odd strides are also exercised with single-bit words, because these show each stage's permutation bit by bit.

// File: rtl/pcheck_pkg.sv
package pcheck_pkg;
  // Source index feeding permuted position k for a given stride
  function automatic int unsigned perm_src(input int unsigned k,
                                           input int unsigned stride,
                                           input int unsigned n);
    return (k * stride) % n;
  endfunction
endpackage

// File: rtl/pcheck_rst_sync.sv
module pcheck_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pcheck_xor_bank.sv
module pcheck_xor_bank #(
  parameter int unsigned M   = 4,
  parameter int unsigned RHO = 4,
  localparam int unsigned N  = M * RHO
) (
  input  logic [N-1:0] perm_word,
  output logic [M-1:0] checks
);
  for (genvar j = 0; j < M; j++) begin : g_chk
    assign checks[j] = ^perm_word[j*RHO +: RHO];
  end
endmodule

// File: rtl/pcheck_stage.sv
module pcheck_stage #(
  parameter int unsigned M      = 4,
  parameter int unsigned RHO    = 4,
  parameter int unsigned STRIDE = 1,
  localparam int unsigned N     = M * RHO
) (
  input  logic [N-1:0] word,
  output logic [M-1:0] syn
);
  import pcheck_pkg::*;

  logic [N-1:0] permuted;

  for (genvar k = 0; k < N; k++) begin : g_perm
    localparam int unsigned SRC = perm_src(k, STRIDE, N);
    assign permuted[k] = word[SRC];
  end

  pcheck_xor_bank #(.M(M), .RHO(RHO)) u_bank (
    .perm_word (permuted),
    .checks    (syn)
  );
endmodule

// File: rtl/stage_gated_checker.sv
module stage_gated_checker #(
  parameter int unsigned GAMMA            = 4,
  parameter int unsigned M                = 4,
  parameter int unsigned RHO              = 4,
  parameter int unsigned STRIDES [GAMMA]  = '{1, 3, 5, 7},
  localparam int unsigned N               = M * RHO,
  localparam int unsigned SW              = GAMMA * M
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N-1:0]     in_word,
  input  logic [GAMMA-1:0] in_mask,
  output logic [SW-1:0]    syn_o,
  output logic [GAMMA-1:0] syn_vld_o
);
  logic             rst_n_sync;
  logic [SW-1:0]    stage_syn;
  logic [SW-1:0]    syn_d, syn_q;
  logic [GAMMA-1:0] vld_d, vld_q;
  logic             upd_en;

  pcheck_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar s = 0; s < GAMMA; s++) begin : g_stage
    pcheck_stage #(.M(M), .RHO(RHO), .STRIDE(STRIDES[s])) u_stage (
      .word (in_word),
      .syn  (stage_syn[s*M +: M])
    );
  end

  // Next-state: gate each stage by the mask captured with the word
  always_comb begin
    for (int s = 0; s < GAMMA; s++) begin
      vld_d[s]       = in_valid & in_mask[s];
      syn_d[s*M +: M] = vld_d[s] ? stage_syn[s*M +: M] : '0;
    end
    upd_en = in_valid | (|vld_q);
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      syn_q <= '0;
      vld_q <= '0;
    end else if (upd_en) begin
      syn_q <= syn_d;
      vld_q <= vld_d;
    end
  end

  assign syn_o     = syn_q;
  assign syn_vld_o = vld_q;
endmodule

// File: rtl/stage_gated_checker_sva.sv
module stage_gated_checker_sva #(
  parameter int unsigned GAMMA = 4,
  parameter int unsigned M     = 4,
  parameter int unsigned N     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [GAMMA-1:0] in_mask,
  input logic [GAMMA*M-1:0] syn_o,
  input logic [GAMMA-1:0] syn_vld_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (syn_vld_o == '0 && syn_o == '0);
    end
  end

  assert_idle_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (syn_vld_o == '0));

  for (genvar s = 0; s < GAMMA; s++) begin : g_chk
    assert_gated_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_vld_o[s] |-> (syn_o[s*M +: M] == '0));
    assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mask[s]) |=> syn_vld_o[s]);
    assert_mask_sampled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mask[s]) |=> !syn_vld_o[s]);
  end
endmodule

bind stage_gated_checker stage_gated_checker_sva #(.GAMMA(GAMMA), .M(M), .N(N)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mask   (in_mask),
  .syn_o     (syn_o),
  .syn_vld_o (syn_vld_o)
);

// File: tb/test_stage_gated_checker.sv
`timescale 1ns/1ps
module test_stage_gated_checker;
  localparam int G = 4;
  localparam int MM = 4;
  localparam int RR = 4;
  localparam int NN = 16;
  localparam int SWID = G * MM;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [NN-1:0]   in_word;
  logic [G-1:0]    in_mask;
  logic [SWID-1:0] syn_o;
  logic [G-1:0]    syn_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tb_stride [G] = '{1, 3, 5, 7};

  logic [SWID-1:0] exp_syn;
  logic [G-1:0]    exp_vld;
  string           exp_tag;

  always #5 clk = ~clk;

  stage_gated_checker i_stage_gated_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_mask(in_mask), .syn_o(syn_o), .syn_vld_o(syn_vld_o)
  );

  function automatic logic [SWID-1:0] model_syn(input logic [NN-1:0] w,
                                                 input logic [G-1:0] m,
                                                 input logic v);
    logic [SWID-1:0] r = '0;
    for (int s = 0; s < G; s++) begin
      if (v && m[s]) begin
        for (int j = 0; j < MM; j++) begin
          logic b = 1'b0;
          for (int q = 0; q < RR; q++) b ^= w[((j*RR + q) * tb_stride[s]) % NN];
          r[s*MM + j] = b;
        end
      end
    end
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (syn_o !== exp_syn || syn_vld_o !== exp_vld) begin
      errors++;
      $display("FAIL %s: syn=%h vld=%b expected syn=%h vld=%b",
               exp_tag, syn_o, syn_vld_o, exp_syn, exp_vld);
    end
  endtask

  // At a falling edge: check the result of the last presented word, then present the next
  task automatic drive(input logic v, input logic [NN-1:0] w,
                       input logic [G-1:0] m, input string tag);
    @(negedge clk);
    compare();
    in_valid = v;
    in_word  = w;
    in_mask  = m;
    exp_syn  = model_syn(w, m, v);
    exp_vld  = v ? m : '0;
    exp_tag  = tag;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_mask = '1;
    exp_syn = '0; exp_vld = '0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    compare();                                 // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare();                                 // R1 after release, nothing accepted yet

    // R8: stage 0 groups are contiguous; one-hot words expose every permutation (R2)
    for (int b = 0; b < NN; b++) drive(1'b1, NN'(1) << b, '1, "R8");
    drive(1'b1, 16'hFFFF, '1, "R2");
    drive(1'b1, 16'h0000, '1, "R2");
    drive(1'b1, 16'h000F, '1, "R8");
    // R2: random words, all stages on
    for (int i = 0; i < 20; i++) drive(1'b1, NN'($urandom), '1, "R2");
    // R4: back-to-back with varying masks
    for (int i = 0; i < 20; i++) drive(1'b1, NN'($urandom), G'($urandom), "R4");
    // R5: disabled stages, including all off
    drive(1'b1, 16'hA5C3, 4'b0000, "R5");
    drive(1'b1, 16'h1234, 4'b0001, "R5");
    drive(1'b1, 16'hBEEF, 4'b1000, "R5");
    drive(1'b1, 16'h7F01, 4'b0110, "R5");
    // R6: the mask changes right after capture
    drive(1'b1, 16'h5A96, 4'b1111, "R6");
    drive(1'b0, 16'h5A96, 4'b0000, "R6");
    drive(1'b1, 16'hC001, 4'b0101, "R6");
    drive(1'b1, 16'hC001, 4'b1010, "R6");
    drive(1'b1, 16'h0F0F, 4'b1111, "R6");
    // R7: idle with mask fully on
    drive(1'b0, 16'hFFFF, 4'b1111, "R7");
    drive(1'b0, 16'h1357, 4'b1111, "R7");
    // R3: isolated words between idle cycles
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, NN'($urandom), '1, "R3");
      drive(1'b0, '0, '1, "R3");
    end
    drive(1'b0, '0, '0, "R7");
    @(negedge clk);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule